// File: doc/BRIEF.md
# Random Generator Command Controller

This block is the register-mapped control front-end of a random number generator. Software writes 4-bit command codes into a control register. The controller checks each code against the generator's current condition and, if the code is legal, runs it for a fixed number of clock cycles with a busy flag raised. When the command completes, it applies the command's effect and raises an interrupt cause.

The controller tracks whether noise has been gathered since the last wipe and whether a generator state exists. A command issued out of order raises an alarm. Interrupt causes are cleared by writing one to them and are combined through per-cause enables and a global enable into a single interrupt line. Four 32-bit output words hold the most recent random block.

A 32-bit Galois shift register stands in for both the entropy source and the deterministic generator. The noise command seeds it with a fixed value. It then advances once for each word it produces, so every output is predictable.

Top module: `rng_cmd_ctrl`

## Requirements
- R1: After reset, every readable register reads zero and the interrupt output is low. This covers status, interrupt status, interrupt enable, alarm, mode, secure mode and the four random words.
- R2: A legal, non-idle command code written to offset 0x00 is recorded in status bits 3:0. Status bit 31 (busy) then stays high for exactly BUSY_CYCLES cycles (default 8), and the command's effect appears when busy falls.
- R3: A control write made while busy is high is dropped. A code outside {0,1,2,3,4,5,6,7,8,15} is ignored. In both cases status bits 3:0 and all stored state stay unchanged, and busy does not rise.
- R4: Code 0 (idle) is accepted and recorded as last command 0. It does not raise busy and leaves the state flag, the interrupt status and the random words untouched.
- R5: Some commands are illegal in the generator's current condition:
  - code 3 when no noise has been gathered since the last wipe;
  - code 4, 6 or 7 while no state exists.

  An illegal command sets alarm bit 4 and interrupt status bit 3. Its code is still recorded in status bits 3:0. It does not raise busy and changes no stored state.
- R6: On completion, the commands act as follows. All stepping uses next = (x >> 1) XOR (x[0] ? 32'h80200003 : 0).
  - Code 1 loads the shift register with 32'h1ACE5EED and marks noise as gathered.
  - Code 3 sets status bit 7 (state exists).
  - Code 6 writes word i (offset 0x24 + 4i) with the register stepped i+1 times, and leaves the register stepped four times.
  - Code 7 steps the register once.
- R7: Code 15 (wipe) clears all four words, status bit 7 and the noise-gathered condition, and sets interrupt status bit 0.
- R8: On completion, code 8 sets interrupt status bit 1 and code 1 sets bit 2. Every other legal, non-idle, non-wipe command sets bit 4.
- R9: Writing ones to interrupt status (offset 0x14) clears those bits and leaves the other bits set.
- R10: The interrupt enable register (offset 0x10) reads back bits 31 and 4:0. The interrupt output is high exactly when bit 31 is set and some bit of (enable[4:0] AND status[4:0]) is set.
- R11: Writing a value with bit 4 set to the alarm register (offset 0x18) clears alarm bit 4. Writing zero clears the whole register. A nonzero write with bit 4 clear leaves the register unchanged.
- R12: The mode register (offset 0x04) keeps bits 4:0 and the secure-mode register (offset 0x08) keeps bits 9:0. In the status register, bit 6 mirrors secure-mode bit 1, bit 5 mirrors secure-mode bit 0, and bit 4 mirrors mode bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 8 | Register byte offset |
| regWe | input | 1 | Write strobe, one cycle per write |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| irqOut | output | 1 | Masked interrupt request |

## Verification
The assertions assume that a control write can only start busy. They also assume that no two state-changing events (a completion and a software clear of the same bit) land on the same edge in a way that matters. The bench keeps to this by always waiting for busy to fall before it writes interrupt status or alarm clears. Command effects on the state flag are checked only through completion strobes, so stimulus always gives each command a full busy window before the next legal write. The single exception is the deliberate write made while busy is high.

// File: rtl/rngc_pkg.sv
package rngc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_SMODE  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_ISTAT  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_ALARM  = 8'h18;
  localparam int               OFS_WORD0  = 'h24;

  localparam logic [3:0] CMD_IDLE    = 4'd0;
  localparam logic [3:0] CMD_NOISE   = 4'd1;
  localparam logic [3:0] CMD_NONCE   = 4'd2;
  localparam logic [3:0] CMD_CREATE  = 4'd3;
  localparam logic [3:0] CMD_RENEW   = 4'd4;
  localparam logic [3:0] CMD_REFRESH = 4'd5;
  localparam logic [3:0] CMD_GEN     = 4'd6;
  localparam logic [3:0] CMD_ADVANCE = 4'd7;
  localparam logic [3:0] CMD_KAT     = 4'd8;
  localparam logic [3:0] CMD_WIPE    = 4'd15;

  // Interrupt cause bit positions
  localparam int IRQ_WIPE  = 0;
  localparam int IRQ_KAT   = 1;
  localparam int IRQ_NOISE = 2;
  localparam int IRQ_ALARM = 3;
  localparam int IRQ_DONE  = 4;
  localparam int IRQ_N     = 5;

  // Strobes from control to datapath, each a single cycle at completion
  typedef struct packed {
    logic seed;
    logic fill;
    logic step;
    logic wipe;
  } dpStrobe_t;

  function automatic logic isKnownCode(input logic [3:0] code);
    case (code)
      CMD_IDLE, CMD_NOISE, CMD_NONCE, CMD_CREATE, CMD_RENEW, CMD_REFRESH,
      CMD_GEN, CMD_ADVANCE, CMD_KAT, CMD_WIPE: isKnownCode = 1'b1;
      default: isKnownCode = 1'b0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lfsrStep(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] mask);
    lfsrStep = (x >> 1) ^ (x[0] ? mask : '0);
  endfunction
endpackage

// File: rtl/rngc_control.sv
module rngc_control
  import rngc_pkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic              busy,
  output logic [3:0]        lastCmd,
  output logic              stateExists,
  output logic [IRQ_N-1:0]  istat,
  output logic [IRQ_N-1:0]  ieCause,
  output logic              ieGlobal,
  output logic [4:0]        alarmReg,
  output logic              irqOut,
  output dpStrobe_t         strobes
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic [3:0]       pendCmd;
  logic             noiseDone;
  logic [3:0]       code;
  logic             ctrlWr, takeCmd, illegalCmd, finish;
  logic [IRQ_N-1:0] setCause;

  assign code    = regWdata[3:0];
  assign busy    = (cnt != '0);
  assign finish  = (cnt == CNT_W'(1));
  assign ctrlWr  = regWe && (regAddr == OFS_CTRL);
  assign takeCmd = ctrlWr && !busy && isKnownCode(code);

  always_comb begin
    illegalCmd = 1'b0;
    if (code == CMD_CREATE && !noiseDone) illegalCmd = 1'b1;
    if ((code == CMD_GEN || code == CMD_RENEW || code == CMD_ADVANCE) && !stateExists)
      illegalCmd = 1'b1;
  end

  always_comb begin
    strobes  = '0;
    setCause = '0;
    if (finish) begin
      case (pendCmd)
        CMD_NOISE:   begin strobes.seed = 1'b1; setCause[IRQ_NOISE] = 1'b1; end
        CMD_GEN:     begin strobes.fill = 1'b1; setCause[IRQ_DONE]  = 1'b1; end
        CMD_ADVANCE: begin strobes.step = 1'b1; setCause[IRQ_DONE]  = 1'b1; end
        CMD_WIPE:    begin strobes.wipe = 1'b1; setCause[IRQ_WIPE]  = 1'b1; end
        CMD_KAT:     setCause[IRQ_KAT]  = 1'b1;
        default:     setCause[IRQ_DONE] = 1'b1;
      endcase
    end
    if (takeCmd && code != CMD_IDLE && illegalCmd) setCause[IRQ_ALARM] = 1'b1;
  end

  // Command sequencing and generator condition
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt         <= '0;
      pendCmd     <= CMD_IDLE;
      lastCmd     <= CMD_IDLE;
      noiseDone   <= 1'b0;
      stateExists <= 1'b0;
    end else begin
      if (takeCmd) begin
        lastCmd <= code;
        if (code != CMD_IDLE && !illegalCmd) begin
          cnt     <= CNT_W'(BUSY_CYCLES);
          pendCmd <= code;
        end
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
      end
      if (finish) begin
        case (pendCmd)
          CMD_NOISE:  noiseDone   <= 1'b1;
          CMD_CREATE: stateExists <= 1'b1;
          CMD_WIPE: begin
            noiseDone   <= 1'b0;
            stateExists <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // Interrupt status, enables and alarm
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      istat    <= '0;
      ieCause  <= '0;
      ieGlobal <= 1'b0;
      alarmReg <= '0;
    end else begin
      if (regWe && regAddr == OFS_ISTAT)
        istat <= (istat & ~regWdata[IRQ_N-1:0]) | setCause;
      else
        istat <= istat | setCause;
      if (regWe && regAddr == OFS_IEN) begin
        ieCause  <= regWdata[IRQ_N-1:0];
        ieGlobal <= regWdata[DATA_W-1];
      end
      if (setCause[IRQ_ALARM])
        alarmReg <= alarmReg | 5'h10;
      else if (regWe && regAddr == OFS_ALARM) begin
        if (regWdata == '0) alarmReg <= '0;
        else if (regWdata[4]) alarmReg <= alarmReg & 5'h0F;
      end
    end
  end

  assign irqOut = ieGlobal && |(ieCause & istat);
endmodule

// File: rtl/rngc_datapath.sv
module rngc_datapath
  import rngc_pkg::*;
#(
  parameter int              NUM_WORDS = 4,
  parameter logic [DATA_W-1:0] SEED    = 32'h1ACE5EED,
  parameter logic [DATA_W-1:0] MASK    = 32'h80200003
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [9:0]        wrLow,
  input  dpStrobe_t         strobes,
  input  logic              busy,
  input  logic [3:0]        lastCmd,
  input  logic              stateExists,
  input  logic [IRQ_N-1:0]  istat,
  input  logic [IRQ_N-1:0]  ieCause,
  input  logic              ieGlobal,
  input  logic [4:0]        alarmReg,
  output logic [DATA_W-1:0] regRdata
);
  logic [4:0]        modeReg;
  logic [9:0]        smodeReg;
  logic [DATA_W-1:0] lfsr;
  logic [DATA_W-1:0] words [NUM_WORDS];
  logic [DATA_W-1:0] chain [NUM_WORDS+1];

  assign chain[0] = lfsr;
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_step
    assign chain[g+1] = lfsrStep(chain[g], MASK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= '0;
      smodeReg <= '0;
      lfsr     <= SEED;
      for (int i = 0; i < NUM_WORDS; i++) words[i] <= '0;
    end else begin
      if (regWe && regAddr == OFS_MODE)  modeReg  <= wrLow[4:0];
      if (regWe && regAddr == OFS_SMODE) smodeReg <= wrLow;
      if (strobes.seed) lfsr <= SEED;
      if (strobes.step) lfsr <= chain[1];
      if (strobes.fill) begin
        lfsr <= chain[NUM_WORDS];
        for (int i = 0; i < NUM_WORDS; i++) words[i] <= chain[i+1];
      end
      if (strobes.wipe)
        for (int i = 0; i < NUM_WORDS; i++) words[i] <= '0;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFS_MODE:   regRdata = {27'b0, modeReg};
      OFS_SMODE:  regRdata = {22'b0, smodeReg};
      OFS_STATUS: regRdata = {busy, 23'b0, stateExists, smodeReg[1], smodeReg[0],
                              modeReg[0], lastCmd};
      OFS_IEN:    regRdata = {ieGlobal, 26'b0, ieCause};
      OFS_ISTAT:  regRdata = {27'b0, istat};
      OFS_ALARM:  regRdata = {27'b0, alarmReg};
      default: begin
        for (int i = 0; i < NUM_WORDS; i++)
          if (regAddr == ADDR_W'(OFS_WORD0 + 4 * i)) regRdata = words[i];
      end
    endcase
  end
endmodule

// File: rtl/rng_cmd_ctrl.sv
module rng_cmd_ctrl
  import rngc_pkg::*;
#(
  parameter int BUSY_CYCLES = 8,
  parameter int NUM_WORDS   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  regAddr,
  input  logic        regWe,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        irqOut
);
  dpStrobe_t        strobes;
  logic             busy, stateExists, ieGlobal;
  logic [3:0]       lastCmd;
  logic [IRQ_N-1:0] istat, ieCause;
  logic [4:0]       alarmReg;

  rngc_control #(.BUSY_CYCLES(BUSY_CYCLES)) i_control (
    .clk, .rstN, .regAddr, .regWe, .regWdata,
    .busy, .lastCmd, .stateExists, .istat, .ieCause, .ieGlobal,
    .alarmReg, .irqOut, .strobes
  );

  rngc_datapath #(.NUM_WORDS(NUM_WORDS)) i_datapath (
    .clk, .rstN, .regAddr, .regWe, .wrLow(regWdata[9:0]), .strobes,
    .busy, .lastCmd, .stateExists, .istat, .ieCause, .ieGlobal,
    .alarmReg, .regRdata
  );
endmodule

// File: rtl/rngc_checker.sv
module rngc_checker
  import rngc_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [7:0]       regAddr,
  input logic             regWe,
  input logic             busy,
  input logic [3:0]       lastCmd,
  input logic             stateExists,
  input logic [IRQ_N-1:0] istat,
  input logic             irqOut,
  input dpStrobe_t        strobes
);
  a_r2_busy_starts_on_ctrl_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWe && regAddr == OFS_CTRL));

  a_r3_last_cmd_frozen_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(lastCmd));

  a_r5_fill_needs_state: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fill || strobes.step) |-> stateExists);

  a_r7_wipe_drops_state: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wipe |=> !stateExists);

  a_r10_no_irq_without_cause: assert property (@(posedge clk) disable iff (!rstN)
    (istat == '0) |-> !irqOut);

  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.seed, strobes.fill, strobes.step, strobes.wipe}));
endmodule

bind rng_cmd_ctrl rngc_checker i_rngc_checker (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .busy(busy),
  .lastCmd(lastCmd), .stateExists(stateExists), .istat(istat),
  .irqOut(irqOut), .strobes(strobes)
);

// File: tb/test_rng_cmd_ctrl.sv
`timescale 1ns/1ps
module test_rng_cmd_ctrl;
  localparam int BUSY = 8;
  localparam logic [31:0] SEED = 32'h1ACE5EED;
  localparam logic [31:0] MASK = 32'h80200003;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] lfsrM;
  logic [31:0] wordM [4];

  always #2 clk = ~clk;

  rng_cmd_ctrl i_rng_cmd_ctrl (.clk, .rstN, .regAddr, .regWe, .regWdata, .regRdata, .irqOut);

  function automatic logic [31:0] stepM(input logic [31:0] x);
    return (x >> 1) ^ (x[0] ? MASK : 32'h0);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  task automatic waitIdle(output int cycles);
    logic [31:0] s;
    cycles = 0;
    rd(8'h0C, s);
    while (s[31] && cycles < 1000) begin
      cycles++;
      @(negedge clk);
      rd(8'h0C, s);
    end
  endtask

  task automatic cmd(input logic [3:0] c);
    int n;
    wr(8'h00, {28'h0, c});
    waitIdle(n);
  endtask

  task automatic checkWords(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(8'(8'h24 + 4 * i), v);
      check(tag, v, wordM[i]);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    foreach (wordM[i]) wordM[i] = '0;
    rd(8'h0C, v); check("R1 status", v, 0);
    rd(8'h14, v); check("R1 istat", v, 0);
    rd(8'h10, v); check("R1 ien", v, 0);
    rd(8'h18, v); check("R1 alarm", v, 0);
    rd(8'h04, v); check("R1 mode", v, 0);
    rd(8'h08, v); check("R1 smode", v, 0);
    checkWords("R1 words");
    check("R1 irq", {31'b0, irqOut}, 0);
  endtask

  task automatic t_noiseGen;
    logic [31:0] v; int n;
    wr(8'h00, 32'd1);
    rd(8'h0C, v); check("R2 last cmd while busy", v, 32'h8000_0001);
    waitIdle(n);
    check("R2 busy length", n, BUSY);
    lfsrM = SEED;
    rd(8'h14, v); check("R8 noise cause", v, 32'h04);
    wr(8'h14, 32'h1F);
    rd(8'h14, v); check("R9 istat cleared", v, 0);
    cmd(4'd3);
    rd(8'h0C, v); check("R6 state exists", v, 32'h83);
    rd(8'h14, v); check("R8 create done cause", v, 32'h10);
    for (int r = 0; r < 2; r++) begin
      cmd(4'd6);
      for (int i = 0; i < 4; i++) begin lfsrM = stepM(lfsrM); wordM[i] = lfsrM; end
      checkWords("R6 generate words");
    end
    cmd(4'd7);
    lfsrM = stepM(lfsrM);
    cmd(4'd6);
    for (int i = 0; i < 4; i++) begin lfsrM = stepM(lfsrM); wordM[i] = lfsrM; end
    checkWords("R6 advance then generate");
    wr(8'h14, 32'h1F);
  endtask

  task automatic t_partialClear;
    logic [31:0] v;
    cmd(4'd8);
    cmd(4'd5);
    rd(8'h14, v); check("R8 kat and refresh causes", v, 32'h12);
    wr(8'h14, 32'h02);
    rd(8'h14, v); check("R9 partial clear", v, 32'h10);
    wr(8'h14, 32'h1F);
  endtask

  task automatic t_busyDrop;
    logic [31:0] v; int n;
    wr(8'h00, 32'd2);
    wr(8'h00, 32'd15);
    waitIdle(n);
    rd(8'h0C, v); check("R3 write during busy dropped", v, 32'h82);
    checkWords("R3 words kept after dropped wipe");
    wr(8'h00, 32'd9);
    rd(8'h0C, v); check("R3 unknown code ignored", v, 32'h82);
    wr(8'h14, 32'h1F);
  endtask

  task automatic t_idle;
    logic [31:0] v;
    wr(8'h00, 32'd0);
    rd(8'h0C, v); check("R4 idle recorded, no busy", v, 32'h80);
    rd(8'h14, v); check("R4 istat untouched", v, 0);
    checkWords("R4 words untouched");
  endtask

  task automatic t_wipeIllegal;
    logic [31:0] v;
    cmd(4'd15);
    foreach (wordM[i]) wordM[i] = '0;
    checkWords("R7 words cleared");
    rd(8'h0C, v); check("R7 state cleared", v, 32'h0F);
    rd(8'h14, v); check("R7 wipe cause", v, 32'h01);
    wr(8'h14, 32'h1F);
    wr(8'h00, 32'd3);
    rd(8'h0C, v); check("R5 illegal create no busy", v, 32'h03);
    rd(8'h18, v); check("R5 alarm bit", v, 32'h10);
    rd(8'h14, v); check("R5 alarm cause", v, 32'h08);
    wr(8'h18, 32'h01);
    rd(8'h18, v); check("R11 nonzero without bit4 keeps", v, 32'h10);
    wr(8'h18, 32'h10);
    rd(8'h18, v); check("R11 w1c alarm", v, 0);
    cmd(4'd1);
    lfsrM = SEED;
    wr(8'h00, 32'd6);
    rd(8'h0C, v); check("R5 illegal generate no state", v, 32'h06);
    checkWords("R5 words unchanged");
    wr(8'h18, 32'h0);
    rd(8'h18, v); check("R11 write zero clears", v, 0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    rd(8'h14, v); check("R10 alarm cause pending", v, 32'h0C);
    wr(8'h10, 32'h0000_0008);
    check("R10 no global enable", {31'b0, irqOut}, 0);
    wr(8'h10, 32'h8000_0008);
    check("R10 enabled pending raises irq", {31'b0, irqOut}, 1);
    rd(8'h10, v); check("R10 enable readback", v, 32'h8000_0008);
    wr(8'h10, 32'h8000_0001);
    check("R10 other cause masked", {31'b0, irqOut}, 0);
    wr(8'h10, 32'h8000_0004);
    check("R10 noise cause enabled", {31'b0, irqOut}, 1);
    wr(8'h14, 32'h1F);
    check("R10 irq drops after clear", {31'b0, irqOut}, 0);
  endtask

  task automatic t_mode;
    logic [31:0] v;
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R12 mode width", v, 32'h1F);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); check("R12 smode width", v, 32'h3FF);
    rd(8'h0C, v); check("R12 status mirrors", v, 32'h76);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_noiseGen;
    t_partialClear;
    t_busyDrop;
    t_idle;
    t_wipeIllegal;
    t_irq;
    t_mode;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule